// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data and direction core of an eight-pin general purpose I/O port on a simple memory-mapped bus. Software can read or write any subset of pins in a single access. The subset is chosen by the address, so no read-modify-write sequence is needed. A 1 KB data window sits at the bottom of the port's address space. Word address bits [9:2] of an access in that window form a per-pin select mask. A read returns only the selected pins. A write changes only selected pins that are also configured as outputs.

A direction register at offset 0x400 sets each pin as an input (0) or an output (1). An output pin drives its data bit. An input pin drives high, and its data bit follows the external pin level, sampled on every clock. Bus accesses use one-cycle read and write strobes. Read data is registered and appears in the cycle after the read strobe. Register updates, and therefore pin outputs, take effect on the clock edge that ends the write strobe.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset the data register and the direction register are zero, every pin output is 1, and read data is zero.
- R2: A read at a window offset (address bits [11:10] = 0) returns, in the cycle after the read strobe, the data register ANDed with address bits [9:2], with bits 31:8 zero. In any cycle that follows a cycle without a read strobe, read data is zero.
- R3: A window write changes exactly the data bits whose address-mask bit (address bits [9:2]) and direction bit are both 1; each such bit takes the matching write-data bit, and every other output-pin data bit keeps its value.
- R4: A write to offset 0x400 loads write-data bits [7:0] into the direction register; a read of 0x400 returns it in bits [7:0], with the upper bits zero.
- R5: A pin whose direction bit is 1 outputs its data bit; a pin whose direction bit is 0 outputs 1.
- R6: For each pin with direction bit 0, the data bit takes the external pin level on every clock edge. For a pin with direction bit 1, the external level has no effect.
- R7: A write becomes visible on the pin outputs at the clock edge that ends the write strobe, and not earlier.
- R8: A read at any offset other than the window and 0x400 returns zero. A write at such an offset changes neither register.
- R9: A read and a write to the window in the same cycle return the contents from before that write. Input pins keep tracking their pads in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after rd_en |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Pin output levels |

## Verification
Two things can change the data register in the same cycle: a masked bus write to output pins, and an input pin that follows its pad. The bench provokes this by changing the pad levels in the same cycle as a window write. That write is also paired with a window read. The bench then checks three results: the read returns the pre-write value, the written output bits take the new value, and the input bits show the new pad levels without any write.

// File: rtl/gpio_mport_pkg.sv
package gpio_mport_pkg;

  localparam int unsigned PORT_PINS = 8;

  typedef logic [PORT_PINS-1:0] pin_vec_t;

  // Pins selected by the address that a read exposes.
  function automatic pin_vec_t f_window_read(pin_vec_t data, pin_vec_t sel);
    return data & sel;
  endfunction

  // Pins a window write may touch: selected and configured as outputs.
  function automatic pin_vec_t f_write_bits(pin_vec_t sel, pin_vec_t dir);
    return sel & dir;
  endfunction

  // Next data value: outputs hold or take the write, inputs track pads.
  function automatic pin_vec_t f_next_data(pin_vec_t data, pin_vec_t dir,
                                           pin_vec_t pads, pin_vec_t wbits,
                                           pin_vec_t wval);
    pin_vec_t outs;
    outs = (data & ~wbits) | (wval & wbits);
    return (outs & dir) | (pads & ~dir);
  endfunction

  // Pin drive: outputs show data, inputs float high.
  function automatic pin_vec_t f_drive(pin_vec_t data, pin_vec_t dir);
    return (data & dir) | ~dir;
  endfunction

endpackage

// File: rtl/gpio_mport_decode.sv
module gpio_mport_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = gpio_mport_pkg::PORT_PINS
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              win_wr,
  output logic              win_rd,
  output logic              dir_wr,
  output logic              dir_rd,
  output logic [PINS-1:0]   sel
);
  localparam int unsigned WIN_BITS = PINS + 2;
  localparam logic [ADDR_W-3:0] DIR_WORD = (ADDR_W-2)'(1) << PINS;

  logic in_window;
  logic at_dir;
  logic unused_byte_lanes;

  assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
  assign at_dir    = (addr[ADDR_W-1:2] == DIR_WORD);
  assign sel       = addr[WIN_BITS-1:2];
  assign unused_byte_lanes = ^addr[1:0];

  assign win_wr = wr_en & in_window;
  assign win_rd = rd_en & in_window;
  assign dir_wr = wr_en & at_dir;
  assign dir_rd = rd_en & at_dir;

endmodule

// File: rtl/gpio_mport_regs.sv
module gpio_mport_regs #(
  parameter int unsigned PINS   = gpio_mport_pkg::PORT_PINS,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_wr,
  input  logic              dir_wr,
  input  logic [PINS-1:0]   sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   data_q,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   wr_bits
);
  import gpio_mport_pkg::*;

  logic [PINS-1:0] wval;
  logic            unused_wdata_hi;

  assign wval            = wdata[PINS-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:PINS];
  assign wr_bits         = win_wr ? f_write_bits(sel, dir_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      data_q <= f_next_data(data_q, dir_q, pin_in, wr_bits, wval);
      if (dir_wr) dir_q <= wval;
    end
  end

  // R1: registers come out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (data_q == '0 && dir_q == '0));

  // R6: input-pin data bits equal the pad level of the previous edge
  p_in_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(pin_in)) & ~$past(dir_q)) == '0));

  // R3: output bits outside the write set hold their value
  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wr_bits)) == '0));

  // R3: bits in the write set take the write data
  p_masked_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bits != '0) |=> (((data_q ^ $past(wval)) & $past(wr_bits)) == '0));

  // R4: direction takes the written value
  p_dir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> (dir_q == $past(wval)));

  // R8: direction changes only through its own offset
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q));

endmodule

// File: rtl/gpio_mport_rdata.sv
module gpio_mport_rdata #(
  parameter int unsigned PINS   = gpio_mport_pkg::PORT_PINS,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_rd,
  input  logic              dir_rd,
  input  logic [PINS-1:0]   sel,
  input  logic [PINS-1:0]   data_q,
  input  logic [PINS-1:0]   dir_q,
  output logic [DATA_W-1:0] rdata
);
  import gpio_mport_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (win_rd)  rdata <= DATA_W'(f_window_read(data_q, sel));
    else if (dir_rd)  rdata <= DATA_W'(dir_q);
    else              rdata <= '0;
  end

  // R2: masked read never shows unselected pins or upper bits
  p_win_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd |=> ((rdata & ~DATA_W'($past(sel))) == '0));

  // R8: accesses outside both decodes read zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_rd && !dir_rd) |=> (rdata == '0));

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PINS   = gpio_mport_pkg::PORT_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out
);
  import gpio_mport_pkg::*;

  logic            win_wr, win_rd, dir_wr, dir_rd;
  logic [PINS-1:0] sel, data_q, dir_q, wr_bits;

  gpio_mport_decode #(.ADDR_W(ADDR_W), .PINS(PINS)) u_decode (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .win_wr (win_wr),
    .win_rd (win_rd),
    .dir_wr (dir_wr),
    .dir_rd (dir_rd),
    .sel    (sel)
  );

  gpio_mport_regs #(.PINS(PINS), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .win_wr  (win_wr),
    .dir_wr  (dir_wr),
    .sel     (sel),
    .wdata   (wdata),
    .pin_in  (pin_in),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .wr_bits (wr_bits)
  );

  gpio_mport_rdata #(.PINS(PINS), .DATA_W(DATA_W)) u_rdata (
    .clk    (clk),
    .rst_n  (rst_n),
    .win_rd (win_rd),
    .dir_rd (dir_rd),
    .sel    (sel),
    .data_q (data_q),
    .dir_q  (dir_q),
    .rdata  (rdata)
  );

  assign pin_out = f_drive(data_q, dir_q);

  // R2: read data is zero after a cycle without a read strobe
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

  // R7: pin outputs move only after a write or when an input-side pad moved
  p_out_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && pin_in == $past(pin_in)) |=> $stable(pin_out));

endmodule

// File: tb/gpio_masked_port_tb.sv
module gpio_masked_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpio_masked_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out)
  );

  localparam logic [11:0] DIR_ADDR = 12'h400;

  // {dir, pads, write mask, write data, read mask, expected read, expected pins}
  localparam int NV = 5;
  localparam logic [55:0] VEC [NV] = '{
    {8'hFF, 8'h00, 8'h0F, 8'hA5, 8'hFF, 8'h05, 8'h05},
    {8'hF0, 8'h0A, 8'hFF, 8'h3C, 8'hFF, 8'h3A, 8'h3F},
    {8'h0F, 8'hC3, 8'h3C, 8'hFF, 8'hF0, 8'hC0, 8'hFC},
    {8'hAA, 8'h55, 8'hAA, 8'h00, 8'h55, 8'h55, 8'h55},
    {8'h81, 8'hFF, 8'h80, 8'h81, 8'hFF, 8'hFE, 8'hFE}
  };

  function automatic logic [11:0] win(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pin_out after reset", {24'h0, pin_out}, 32'h0000_00FF);
    check("R1 rdata after reset", rdata, 32'h0);
    bus_read(DIR_ADDR, rd);
    check("R1 direction after reset", rd, 32'h0);
    bus_read(win(8'hFF), rd);
    check("R1 data after reset", rd, 32'h0);
    @(negedge clk);
    check("R2 rdata idle after read", rdata, 32'h0);

    // Vector table: R2 R3 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [7:0] d, p, m, w, rm, er, eo;
      {d, p, m, w, rm, er, eo} = VEC[i];
      bus_write(DIR_ADDR, 32'hFF);
      bus_write(win(8'hFF), 32'h0);
      bus_write(DIR_ADDR, {24'h0, d});
      pin_in = p;
      bus_write(win(m), {24'hFFFFFF, w});
      bus_read(win(rm), rd);
      check($sformatf("R2/R3/R6 vector %0d read", i), rd, {24'h0, er});
      check($sformatf("R5 vector %0d pin_out", i), {24'h0, pin_out}, {24'h0, eo});
    end

    // R4 direction readback
    bus_write(DIR_ADDR, 32'hABCD_12F0);
    bus_read(DIR_ADDR, rd);
    check("R4 direction readback", rd, 32'h0000_00F0);

    // R7 write visible only after the strobe's edge
    pin_in = 8'h00;
    bus_write(DIR_ADDR, 32'hFF);
    bus_write(win(8'hFF), 32'h0);
    @(negedge clk);
    wr_en = 1'b1; addr = win(8'hFF); wdata = 32'h5A;
    #5;
    check("R7 pin_out before edge", {24'h0, pin_out}, 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 pin_out after edge", {24'h0, pin_out}, 32'h5A);

    // R6 output pins ignore pads, input pins track without a write
    bus_write(DIR_ADDR, 32'hF0);
    pin_in = 8'hAF;
    repeat (2) @(negedge clk);
    bus_read(win(8'hFF), rd);
    check("R6 pads on outputs ignored, inputs tracked", rd, 32'h5F);

    // R9 read and write together while pads change
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = win(8'hFF); wdata = 32'hC0; pin_in = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 same-cycle read returns old data", rdata, 32'h5F);
    bus_read(win(8'hFF), rd);
    check("R9 write and pad change both landed", rd, 32'hC3);
    check("R5 pin_out mixed", {24'h0, pin_out}, 32'hCF);

    // R8 unmapped offsets
    bus_read(12'h404, rd);
    check("R8 read 0x404", rd, 32'h0);
    bus_read(12'h800, rd);
    check("R8 read 0x800", rd, 32'h0);
    bus_write(12'h404, 32'hFF);
    bus_write(12'hC00, 32'hFF);
    bus_read(DIR_ADDR, rd);
    check("R8 direction untouched", rd, 32'hF0);
    bus_read(win(8'hFF), rd);
    check("R8 data untouched", rd, 32'hC3);

    finish_run();
  end

endmodule